// File: doc/BRIEF.md
# Three-Bus Processor Datapath with Step Sequencer

This block is a small processor core built around three internal buses. Two source buses carry operands out of a register file that has two read ports. A destination bus carries the ALU result back into a register, the program counter, the memory address register or the instruction register. A dedicated adder advances the program counter, so the ALU stays free during fetch. The ALU can also copy either of its operands to the destination bus unchanged. This pass-through is how addresses, fetched words and immediates move between registers.

A four-step sequencer drives the control lines for each instruction:
1. Latch the PC into the address register, start a read and advance the PC.
2. Hold until the memory reports that the read has completed, then capture the returned word.
3. Move the captured word into the instruction register.
4. Read two registers, combine them and write a third, all in one clock.

Each register write is reported at the ports together with an end-of-instruction pulse. This lets the surrounding system or a bench follow the architectural state.

Top module: `tribus_cpu`

## Requirements
- R1: While `rst` is high, and in the cycle after its last high edge, `pc_out` equals RESET_PC (default 0), and `mem_rd`, `wb_valid` and `instr_end` are low. The first read after reset uses address RESET_PC.
- R2: Step 1 of every instruction makes `mem_rd` rise with `mem_addr` equal to the PC of that instruction. In the same cycle, `pc_out` shows that PC plus 4.
- R3: While `mem_rd` is high and `mem_done` is low, `mem_rd` stays high and `pc_out` and `mem_addr` hold their values. The cycle after `mem_done` is seen high, `mem_rd` is low.
- R4: `instr_end` pulses exactly 3+W cycles after `mem_rd` rises, where W is the number of cycles with `mem_done` low. So an instruction takes 4 clocks with no wait. The next `mem_rd` rise follows one cycle after `instr_end`.
- R5: Instruction word fields are opcode [31:28], destination [26:24], source A [22:20], source B [18:16] and immediate [15:0]. Bits 27, 23 and 19 are reserved. Opcode 1 writes A+B and opcode 2 writes A-B, both modulo 2^32. The write is reported by `wb_valid`, `wb_reg` and `wb_data` in the `instr_end` cycle.
- R6: Opcode 3 writes A AND B, opcode 4 writes A OR B, and opcode 5 writes A XOR B.
- R7: Opcode 6 writes source A unchanged and opcode 7 writes source B unchanged.
- R8: Opcode 8 writes the 16-bit immediate, sign-extended to 32 bits.
- R9: When the destination is also a source, the operand is the register value from before the instruction.
- R10: Opcode 0, opcodes 9 to 15, and any word with a reserved bit set write no register. `wb_valid` stays low, and `instr_end` still pulses on time.
- R11: A `mem_done` pulse in any cycle where `mem_rd` is low has no effect on sequencing or results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | DATA_W | Word returned by memory, valid with `mem_done` |
| mem_done | input | 1 | Memory reports that the read has completed |
| mem_addr | output | DATA_W | Memory address register |
| mem_rd | output | 1 | Read request, held until completion |
| pc_out | output | DATA_W | Current program counter |
| wb_valid | output | 1 | A register was written by the instruction just finished |
| wb_reg | output | $clog2(NREG) | Index of the register written |
| wb_data | output | DATA_W | Value written |
| instr_end | output | 1 | Pulse marking the end of an instruction |

## Verification
A wrong sequencer step shows at the ports within one instruction. If `mem_rd` rises at the wrong time or falls too early, or `instr_end` is off by a cycle, the fault appears in the step count between fetch start and end. A wrong PC or address register appears at the next fetch, because each read address is compared against the expected one. Corrupt register contents appear at the first later instruction that reads that register, because every write is compared against a reference register model. The program is arranged so that each register is reused within a few instructions.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  localparam int OP_LSB  = 28;
  localparam int RD_LSB  = 24;
  localparam int RA_LSB  = 20;
  localparam int RB_LSB  = 16;
  localparam int SLOT_W  = 4;
  localparam int IMM_W   = 16;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_PASSA = 4'd6,
    OP_PASSB = 4'd7,
    OP_IMM   = 4'd8
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH   = 2'd0,
    ST_WAIT    = 2'd1,
    ST_LOAD_IR = 2'd2,
    ST_EXEC    = 2'd3
  } step_e;

  typedef enum logic [2:0] {
    ALU_ADD    = 3'd0,
    ALU_SUB    = 3'd1,
    ALU_AND    = 3'd2,
    ALU_OR     = 3'd3,
    ALU_XOR    = 3'd4,
    ALU_PASS_A = 3'd5,
    ALU_PASS_B = 3'd6
  } alu_fn_e;

  typedef enum logic [1:0] {
    BSRC_REG = 2'd0,
    BSRC_PC  = 2'd1,
    BSRC_MDR = 2'd2,
    BSRC_IMM = 2'd3
  } bsrc_e;

  typedef struct packed {
    logic    mar_in;
    logic    read;
    logic    inc_pc;
    logic    mdr_in;
    logic    ir_in;
    logic    rf_we;
    logic    end_step;
    bsrc_e   bsrc;
    alu_fn_e alu_fn;
  } ctrl_t;

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] store [NREG];

  // Single write port; reads see the contents before this edge's write.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata_a = store[raddr_a];
  assign rdata_b = store[raddr_b];

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (fn)
      ALU_ADD:    y = a + b;
      ALU_SUB:    y = a - b;
      ALU_AND:    y = a & b;
      ALU_OR:     y = a | b;
      ALU_XOR:    y = a ^ b;
      ALU_PASS_A: y = a;
      ALU_PASS_B: y = b;
      default:    y = b;
    endcase
  end

endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_done,
  input  logic [3:0] opcode,
  input  logic       resv_nz,
  output ctrl_t      ctl
);

  step_e step_q, step_d;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_FETCH;
    else     step_q <= step_d;
  end

  always_comb begin
    unique case (step_q)
      ST_FETCH:   step_d = ST_WAIT;
      ST_WAIT:    step_d = mem_done ? ST_LOAD_IR : ST_WAIT;
      ST_LOAD_IR: step_d = ST_EXEC;
      default:    step_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.bsrc   = BSRC_REG;
    ctl.alu_fn = ALU_PASS_B;
    unique case (step_q)
      ST_FETCH: begin
        ctl.bsrc   = BSRC_PC;
        ctl.mar_in = 1'b1;
        ctl.read   = 1'b1;
        ctl.inc_pc = 1'b1;
      end
      ST_WAIT: begin
        ctl.mdr_in = mem_done;
      end
      ST_LOAD_IR: begin
        ctl.bsrc  = BSRC_MDR;
        ctl.ir_in = 1'b1;
      end
      default: begin
        ctl.end_step = 1'b1;
        ctl.rf_we    = !resv_nz;
        unique case (opcode_e'(opcode))
          OP_ADD:   ctl.alu_fn = ALU_ADD;
          OP_SUB:   ctl.alu_fn = ALU_SUB;
          OP_AND:   ctl.alu_fn = ALU_AND;
          OP_OR:    ctl.alu_fn = ALU_OR;
          OP_XOR:   ctl.alu_fn = ALU_XOR;
          OP_PASSA: ctl.alu_fn = ALU_PASS_A;
          OP_PASSB: ctl.alu_fn = ALU_PASS_B;
          OP_IMM: begin
            ctl.alu_fn = ALU_PASS_B;
            ctl.bsrc   = BSRC_IMM;
          end
          default:  ctl.rf_we = 1'b0;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/tribus_cpu.sv
module tribus_cpu
  import tribus_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NREG     = 8,
  parameter int RESET_PC = 0,
  parameter int PC_STEP  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_done,
  output logic [DATA_W-1:0]       mem_addr,
  output logic                    mem_rd,
  output logic [DATA_W-1:0]       pc_out,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic [DATA_W-1:0]       wb_data,
  output logic                    instr_end
);

  localparam int AW = $clog2(NREG);

  logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic              rd_q;
  logic [DATA_W-1:0] bus_a, bus_b, bus_c, rf_b, imm_ext;
  logic [AW-1:0]     dst_idx, src_a_idx, src_b_idx;
  logic              resv_nz;
  ctrl_t             ctl;

  assign dst_idx   = ir_q[RD_LSB +: AW];
  assign src_a_idx = ir_q[RA_LSB +: AW];
  assign src_b_idx = ir_q[RB_LSB +: AW];
  assign imm_ext   = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  // Bits of each register slot above the index width are reserved.
  generate
    if (AW < SLOT_W) begin : g_resv
      assign resv_nz = |{ir_q[RD_LSB+AW +: SLOT_W-AW],
                         ir_q[RA_LSB+AW +: SLOT_W-AW],
                         ir_q[RB_LSB+AW +: SLOT_W-AW]};
    end else begin : g_no_resv
      assign resv_nz = 1'b0;
    end
  endgenerate

  tribus_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mem_done (mem_done),
    .opcode   (ir_q[OP_LSB +: 4]),
    .resv_nz  (resv_nz),
    .ctl      (ctl)
  );

  tribus_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (ctl.rf_we),
    .waddr   (dst_idx),
    .wdata   (bus_c),
    .raddr_a (src_a_idx),
    .raddr_b (src_b_idx),
    .rdata_a (bus_a),
    .rdata_b (rf_b)
  );

  always_comb begin
    unique case (ctl.bsrc)
      BSRC_PC:  bus_b = pc_q;
      BSRC_MDR: bus_b = mdr_q;
      BSRC_IMM: bus_b = imm_ext;
      default:  bus_b = rf_b;
    endcase
  end

  tribus_alu #(.DW(DATA_W)) u_alu (
    .fn (ctl.alu_fn),
    .a  (bus_a),
    .b  (bus_b),
    .y  (bus_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= DATA_W'(RESET_PC);
      mar_q     <= '0;
      mdr_q     <= '0;
      ir_q      <= '0;
      rd_q      <= 1'b0;
      wb_valid  <= 1'b0;
      wb_reg    <= '0;
      wb_data   <= '0;
      instr_end <= 1'b0;
    end else begin
      if (ctl.inc_pc) pc_q  <= pc_q + DATA_W'(PC_STEP);
      if (ctl.mar_in) mar_q <= bus_c;
      if (ctl.mdr_in) mdr_q <= mem_rdata;
      if (ctl.ir_in)  ir_q  <= bus_c;
      if (ctl.read)        rd_q <= 1'b1;
      else if (ctl.mdr_in) rd_q <= 1'b0;
      wb_valid  <= ctl.rf_we;
      wb_reg    <= dst_idx;
      wb_data   <= bus_c;
      instr_end <= ctl.end_step;
    end
  end

  assign mem_addr = mar_q;
  assign mem_rd   = rd_q;
  assign pc_out   = pc_q;

endmodule

// File: rtl/tribus_cpu_chk.sv
module tribus_cpu_chk #(
  parameter int DATA_W   = 32,
  parameter int RESET_PC = 0,
  parameter int PC_STEP  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_done,
  input logic              mem_rd,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] pc_out,
  input logic              wb_valid,
  input logic              instr_end
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc_out == DATA_W'(RESET_PC) && !mem_rd && !wb_valid && !instr_end));

  p_pc_ahead_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> (pc_out == mem_addr + DATA_W'(PC_STEP)));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_done) |=> (mem_rd && $stable(pc_out) && $stable(mem_addr)));

  p_read_release_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_done) |=> !mem_rd);

  p_next_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    instr_end |=> mem_rd);

  p_end_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    instr_end |-> !mem_rd);

  p_write_at_end_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> instr_end);

endmodule

bind tribus_cpu tribus_cpu_chk #(
  .DATA_W   (DATA_W),
  .RESET_PC (RESET_PC),
  .PC_STEP  (PC_STEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_done  (mem_done),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .pc_out    (pc_out),
  .wb_valid  (wb_valid),
  .instr_end (instr_end)
);

// File: tb/tribus_cpu_test.sv
module tribus_cpu_test;

  localparam int DW    = 32;
  localparam int NR    = 8;
  localparam int AW    = 3;
  localparam int NPROG = 24;
  localparam int LIMIT = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_done  = 1'b0;
  logic [DW-1:0] mem_addr, pc_out, wb_data;
  logic          mem_rd, wb_valid, instr_end;
  logic [AW-1:0] wb_reg;

  always #4 clk = ~clk;

  tribus_cpu #(.DATA_W(DW), .NREG(NR)) uut (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_done  (mem_done),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .pc_out    (pc_out),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .wb_data   (wb_data),
    .instr_end (instr_end)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(input int op, input int rd, input int ra,
                                        input int rb, input logic [15:0] imm);
    logic [3:0] o = op[3:0];
    logic [2:0] d = rd[2:0];
    logic [2:0] a = ra[2:0];
    logic [2:0] b = rb[2:0];
    return {o, 1'b0, d, 1'b0, a, 1'b0, b, imm};
  endfunction

  logic [DW-1:0] prog   [NPROG];
  logic [DW-1:0] rf_ref [NR];

  function automatic logic [DW-1:0] word_at(input logic [DW-1:0] addr);
    if ((addr >> 2) < NPROG) return prog[addr >> 2];
    return '0;
  endfunction

  logic [DW-1:0] fq [$];
  int            lq [$];
  int            rq [$];

  int            cyc = 0, mfetch = 0, rfetch = 0, wcnt = 0, ends = 0;
  bit            running = 0, stray = 0, prev_rd = 0, prev_end = 0;
  logic [DW-1:0] prev_pc = '0, prev_addr = '0, exp_pc = '0;

  always @(negedge clk) begin
    cyc++;
    if (running) begin
      // Fetch start: address and incremented PC (R1 for the first one, R2)
      if (mem_rd && !prev_rd) begin
        chk(mem_addr == exp_pc, (mfetch == 0) ? "R1" : "R2", "fetch address", mem_addr, exp_pc);
        chk(pc_out == exp_pc + 4, "R2", "pc after increment", pc_out, exp_pc + 4);
        fq.push_back(word_at(exp_pc));
        lq.push_back(mfetch % 3);
        rq.push_back(cyc);
        mfetch++;
        exp_pc += 4;
        if (mfetch >= 12) stray = 1'b1;
      end else if (mem_rd && prev_rd) begin
        chk(pc_out == prev_pc, "R3", "pc held during wait", pc_out, prev_pc);
        chk(mem_addr == prev_addr, "R3", "address held during wait", mem_addr, prev_addr);
      end
      if (prev_end) chk(mem_rd, "R4", "fetch follows end", {31'b0, mem_rd}, 32'd1);
      if (instr_end) begin
        if (fq.size() == 0) begin
          chk(1'b0, "R4", "end without fetch", 32'd1, 32'd0);
        end else begin
          logic [DW-1:0] w, a, b, v;
          int            lat, rise;
          bit            writes;
          string         req;
          w    = fq.pop_front();
          lat  = lq.pop_front();
          rise = rq.pop_front();
          chk(cyc - rise == 3 + lat, "R4", "cycles fetch to end", cyc - rise, 3 + lat);
          a      = rf_ref[w[22:20]];
          b      = rf_ref[w[18:16]];
          writes = 1'b1;
          v      = '0;
          req    = "R10";
          case (w[31:28])
            4'd1: begin v = a + b; req = "R5"; end
            4'd2: begin v = a - b; req = "R5"; end
            4'd3: begin v = a & b; req = "R6"; end
            4'd4: begin v = a | b; req = "R6"; end
            4'd5: begin v = a ^ b; req = "R6"; end
            4'd6: begin v = a;     req = "R7"; end
            4'd7: begin v = b;     req = "R7"; end
            4'd8: begin v = {{16{w[15]}}, w[15:0]}; req = "R8"; end
            default: writes = 1'b0;
          endcase
          if (w[27] || w[23] || w[19]) begin
            writes = 1'b0;
            req    = "R10";
          end
          if (writes && w[31:28] != 4'd8 &&
              (w[26:24] == w[22:20] || w[26:24] == w[18:16])) req = "R9";
          if (stray) req = {req, "/R11"};
          if (writes) begin
            chk(wb_valid, req, "write reported", {31'b0, wb_valid}, 32'd1);
            chk(wb_reg == w[26:24], req, "destination", {29'b0, wb_reg}, {29'b0, w[26:24]});
            chk(wb_data == v, req, "result", wb_data, v);
            rf_ref[w[26:24]] = v;
          end else begin
            chk(!wb_valid, req, "no write", {31'b0, wb_valid}, 32'd0);
          end
        end
        ends++;
      end
    end
    // Memory responder: latency per fetch is fetch index mod 3
    if (mem_rd) begin
      if (wcnt == rfetch % 3) begin
        mem_done  = 1'b1;
        mem_rdata = word_at(mem_addr);
        wcnt      = 0;
        rfetch++;
      end else begin
        mem_done = 1'b0;
        wcnt++;
      end
    end else begin
      mem_done  = stray && (cyc % 2 == 1);
      mem_rdata = 32'hDEAD_BEEF;
    end
    prev_rd   = mem_rd;
    prev_end  = instr_end;
    prev_pc   = pc_out;
    prev_addr = mem_addr;
  end

  initial begin
    prog[0]  = enc(8, 0, 0, 0, 16'h0005);
    prog[1]  = enc(8, 1, 0, 0, 16'hFFFD);
    prog[2]  = enc(8, 2, 0, 0, 16'h7FFF);
    prog[3]  = enc(8, 3, 0, 0, 16'h8000);
    prog[4]  = enc(8, 4, 0, 0, 16'h1234);
    prog[5]  = enc(8, 5, 0, 0, 16'h00F0);
    prog[6]  = enc(8, 6, 0, 0, 16'h0FF0);
    prog[7]  = enc(8, 7, 0, 0, 16'h0001);
    prog[8]  = enc(1, 4, 0, 1, 16'h0);
    prog[9]  = enc(2, 5, 0, 2, 16'h0);
    prog[10] = enc(2, 6, 3, 2, 16'h0);
    prog[11] = enc(3, 7, 2, 3, 16'h0);
    prog[12] = enc(4, 0, 5, 6, 16'h0);
    prog[13] = enc(5, 1, 6, 4, 16'h0);
    prog[14] = enc(6, 2, 7, 0, 16'h0);
    prog[15] = enc(7, 3, 7, 0, 16'h0);
    prog[16] = enc(0, 1, 2, 3, 16'h0);
    prog[17] = enc(15, 1, 2, 3, 16'h0);
    prog[18] = enc(1, 5, 5, 5, 16'h0);
    prog[19] = enc(2, 6, 6, 6, 16'h0);
    prog[20] = enc(1, 0, 1, 2, 16'h0) | 32'h0800_0000;
    prog[21] = enc(1, 7, 2, 3, 16'h0);
    prog[22] = enc(5, 4, 4, 1, 16'h0);
    prog[23] = enc(7, 0, 0, 7, 16'h0);
    for (int i = 0; i < NR; i++) rf_ref[i] = '0;

    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pc_out == '0, "R1", "reset pc", pc_out, '0);
    chk(!mem_rd, "R1", "reset read", {31'b0, mem_rd}, 32'd0);
    chk(!wb_valid, "R1", "reset write flag", {31'b0, wb_valid}, 32'd0);
    chk(!instr_end, "R1", "reset end", {31'b0, instr_end}, 32'd0);
    rst     = 1'b0;
    running = 1'b1;

    while (ends < NPROG && cyc < LIMIT) @(negedge clk);
    if (ends < NPROG) chk(1'b0, "R4", "watchdog expired", ends, NPROG);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule